// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This block sits next to an I2C master/slave shift engine and decides what happens when software asks to become bus master. If the bus monitor reports the bus as free, the controller issues a one-cycle start-generate strobe at once and raises the master-status flag. If the bus is busy and reservations are enabled, the request is held as a pending reservation. The start then fires by itself on the first stop condition seen on the bus. With reservations disabled, a request on a busy bus is simply dropped.

A pending reservation is cancelled when the device is addressed as a slave before the bus is released. The controller also guards the outgoing address byte. A byte written while a reservation is waiting is thrown away, and any byte held from before is cleared when the reserved start fires. Only a byte written after the start belongs to the reserved transfer.

Each start request also starts a wait timer. Its length comes from a 4-bit speed/clock-select code, and it ends with a one-cycle done pulse. Software reads the master-status flag at that point to learn whether the start went out or is still reserved. A stop-detect interrupt output can be enabled so software sees bus releases.

Top module: `i2c_start_resv`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `start_gen`, `master_sts`, `resv_pend`, `wait_done`, `stop_irq` and `launch_valid` are all 0.
- R2: A `start_req` sampled while idle with `bus_free`=1 makes `start_gen` high for exactly the next cycle, and `master_sts` goes to 1 in that same cycle.
- R3: A `start_req` sampled while idle with `bus_free`=0 and `resv_dis`=0 sets `resv_pend` in the next cycle and produces no `start_gen`.
- R4: A `start_req` sampled while idle with `bus_free`=0 and `resv_dis`=1 is dropped. `resv_pend`, `master_sts` and `start_gen` stay 0, and a later `stop_det` creates no start.
- R5: A `stop_det` sampled while a reservation is pending (and `slave_hit`=0) gives, in the next cycle, `start_gen`=1, `master_sts`=1 and `resv_pend`=0.
- R6: A `slave_hit` sampled while a reservation is pending clears `resv_pend` in the next cycle, even if `stop_det` is high in the same cycle. No start follows, either then or on a later stop.
- R7: A `start_req` sampled while a reservation is pending or while `master_sts`=1 changes neither `resv_pend` nor `master_sts`, and it produces no `start_gen`.
- R8: Every sampled `start_req` (re)loads the wait timer. `wait_done` is high for one cycle, exactly N clock edges after the sampling edge. N depends on `speed_code[3:2]`/`speed_code[1:0]`: 00/0..3 give 101, 85, 43, 23; 01/0..3 give 51, 27, 27, 15; 1x/0..3 give 27, 15, 9, 9.
- R9: An `addr_wr` sampled while a reservation is pending is discarded. A reserved start firing clears `launch_valid`. An `addr_wr` sampled at any other time sets `launch_valid`=1 and `launch_addr`=`addr_in` in the next cycle.
- R10: A `master_drop` sampled while `master_sts`=1 clears `master_sts` and `launch_valid` in the next cycle.
- R11: `stop_irq` is high in the cycle after `stop_det` and `stop_ie` are both sampled high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Software start request, one-cycle pulse |
| resv_dis | input | 1 | 1 disables reservations (active-low enable) |
| bus_free | input | 1 | Bus monitor: bus released |
| stop_det | input | 1 | Bus monitor: stop condition seen |
| slave_hit | input | 1 | Engine: own slave address matched |
| master_drop | input | 1 | Engine: master role ended (arbitration loss or own stop) |
| stop_ie | input | 1 | Stop-detect interrupt enable |
| speed_code | input | 4 | Speed/clock-select code for the wait period |
| addr_wr | input | 1 | Write strobe for the outgoing address byte |
| addr_in | input | ADDR_W | Address byte to send |
| start_gen | output | 1 | One-cycle strobe: generate start condition |
| master_sts | output | 1 | Device holds master status |
| resv_pend | output | 1 | A start reservation is waiting |
| wait_done | output | 1 | One-cycle pulse at the end of the wait period |
| stop_irq | output | 1 | Stop-detect interrupt |
| launch_addr | output | ADDR_W | Address byte held for the transfer |
| launch_valid | output | 1 | `launch_addr` holds a usable byte |

## Verification
On every cycle the assertions check several relations. A start strobe always comes with master status, and pending and master are never set together. A reservation fires or is cancelled in exactly one cycle, and a disabled reservation never queues. Writes during a pending reservation never touch the address buffer, the wait-timer done pulse never lasts more than one cycle, and the interrupt follows an enabled stop. Some things only the bench scenarios can show. These are the exact wait length for every speed code, and that the timer restarts on a new request. The bench also shows the full pre-written, discarded and post-stop address sequence around a reserved start, and the cancel-then-stop sequence that must not produce a start later.

// File: rtl/i2c_rsv_pkg.sv
package i2c_rsv_pkg;

  localparam int CODE_W = 4;
  localparam int LEN_W  = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_MSTR = 2'd2
  } rsv_state_t;

  // Wait length in input clocks for each speed/clock-select code.
  function automatic logic [LEN_W-1:0] wait_len(input logic [CODE_W-1:0] code);
    logic [LEN_W-1:0] len;
    if (code[3]) begin
      case (code[1:0])
        2'd0:    len = 7'd27;
        2'd1:    len = 7'd15;
        default: len = 7'd9;
      endcase
    end else if (code[2]) begin
      case (code[1:0])
        2'd0:    len = 7'd51;
        2'd3:    len = 7'd15;
        default: len = 7'd27;
      endcase
    end else begin
      case (code[1:0])
        2'd0:    len = 7'd101;
        2'd1:    len = 7'd85;
        2'd2:    len = 7'd43;
        default: len = 7'd23;
      endcase
    end
    return len;
  endfunction

endpackage

// File: rtl/rsv_wait_timer.sv
module rsv_wait_timer
  import i2c_rsv_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output logic              done
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        cnt_q  <= CNT_W'(wait_len(code));
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(1)) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign done = done_q;

  // R8: done is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_q && !load |=> !done_q);

  // R8: a running count never sits at zero
  p_busy_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cnt_q != '0);

endmodule

// File: rtl/rsv_ctrl_fsm.sv
module rsv_ctrl_fsm
  import i2c_rsv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic bus_free,
  input  logic resv_dis,
  input  logic stop_det,
  input  logic slave_hit,
  input  logic master_drop,
  output logic start_gen,
  output logic master_sts,
  output logic resv_pend,
  output logic fire_now,
  output logic drop_now
);

  rsv_state_t state_q, state_d;
  logic       gen_q, gen_d;

  always_comb begin
    state_d  = state_q;
    gen_d    = 1'b0;
    fire_now = 1'b0;
    drop_now = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          if (bus_free) begin
            state_d = ST_MSTR;
            gen_d   = 1'b1;
          end else if (!resv_dis) begin
            state_d = ST_PEND;
          end
        end
      end
      ST_PEND: begin
        if (slave_hit) begin
          state_d = ST_IDLE;
        end else if (stop_det) begin
          state_d  = ST_MSTR;
          gen_d    = 1'b1;
          fire_now = 1'b1;
        end
      end
      ST_MSTR: begin
        if (master_drop) begin
          state_d  = ST_IDLE;
          drop_now = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      gen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      gen_q   <= gen_d;
    end
  end

  assign start_gen  = gen_q;
  assign master_sts = (state_q == ST_MSTR);
  assign resv_pend  = (state_q == ST_PEND);

  // R2: a start strobe is always accompanied by master status
  p_gen_with_master_r2: assert property (@(posedge clk) disable iff (rst)
    gen_q |-> master_sts);

  // R2: the strobe never lasts two cycles
  p_gen_single_r2: assert property (@(posedge clk) disable iff (rst)
    gen_q |=> !gen_q);

  // R3: pending and master are exclusive
  p_pend_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(resv_pend && master_sts));

  // R4: a disabled reservation is never queued
  p_no_queue_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_req && !bus_free && resv_dis)
      |=> !resv_pend && !gen_q);

  // R5: stop launches a pending reservation in one cycle
  p_fire_r5: assert property (@(posedge clk) disable iff (rst)
    (resv_pend && stop_det && !slave_hit)
      |=> gen_q && master_sts && !resv_pend);

  // R6: slave addressing cancels the reservation
  p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    (resv_pend && slave_hit) |=> !resv_pend && !gen_q && !master_sts);

  // R7: a request while master has no effect
  p_req_in_master_r7: assert property (@(posedge clk) disable iff (rst)
    (master_sts && start_req && !master_drop) |=> master_sts && !gen_q);

endmodule

// File: rtl/rsv_addr_hold.sv
module rsv_addr_hold #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] din,
  input  logic              blocked,
  input  logic              clr,
  output logic [ADDR_W-1:0] addr,
  output logic              vld
);

  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else if (wr && !blocked) begin
      addr_q <= din;
      vld_q  <= 1'b1;
    end else if (clr) begin
      vld_q  <= 1'b0;
    end
  end

  assign addr = addr_q;
  assign vld  = vld_q;

  // R9: writes during a pending reservation leave the buffer untouched
  p_discard_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && blocked && !clr) |=> $stable(addr_q) && $stable(vld_q));

  // R9: a clear without a write empties the buffer
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !(wr && !blocked)) |=> !vld_q);

endmodule

// File: rtl/i2c_start_resv.sv
module i2c_start_resv
  import i2c_rsv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              resv_dis,
  input  logic              bus_free,
  input  logic              stop_det,
  input  logic              slave_hit,
  input  logic              master_drop,
  input  logic              stop_ie,
  input  logic [3:0]        speed_code,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              start_gen,
  output logic              master_sts,
  output logic              resv_pend,
  output logic              wait_done,
  output logic              stop_irq,
  output logic [ADDR_W-1:0] launch_addr,
  output logic              launch_valid
);

  logic fire_now;
  logic drop_now;
  logic irq_q;

  rsv_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .bus_free    (bus_free),
    .resv_dis    (resv_dis),
    .stop_det    (stop_det),
    .slave_hit   (slave_hit),
    .master_drop (master_drop),
    .start_gen   (start_gen),
    .master_sts  (master_sts),
    .resv_pend   (resv_pend),
    .fire_now    (fire_now),
    .drop_now    (drop_now)
  );

  rsv_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (start_req),
    .code (speed_code),
    .done (wait_done)
  );

  rsv_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .wr      (addr_wr),
    .din     (addr_in),
    .blocked (resv_pend),
    .clr     (fire_now | drop_now),
    .addr    (launch_addr),
    .vld     (launch_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= stop_det & stop_ie;
  end

  assign stop_irq = irq_q;

  // R11: an enabled stop raises the interrupt next cycle
  p_stop_irq_r11: assert property (@(posedge clk) disable iff (rst)
    (stop_det && stop_ie) |=> stop_irq);

  // R11: no interrupt while disabled
  p_stop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !stop_ie |=> !stop_irq);

  // R10: dropping master clears the launch buffer
  p_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (master_sts && master_drop && !addr_wr) |=> !master_sts && !launch_valid);

endmodule

// File: tb/i2c_start_resv_tb_top.sv
module i2c_start_resv_tb_top;

  localparam int CLK_NS = 4;
  localparam int NVEC   = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 0, resv_dis = 0, bus_free = 0, stop_det = 0;
  logic       slave_hit = 0, master_drop = 0, stop_ie = 0, addr_wr = 0;
  logic [3:0] speed_code = 0;
  logic [7:0] addr_in = 0;
  logic       start_gen, master_sts, resv_pend, wait_done, stop_irq, launch_valid;
  logic [7:0] launch_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // {speed_code, expected wait length} per R8
  localparam logic [10:0] VEC [NVEC] = '{
    {4'h0, 7'd101}, {4'h1, 7'd85}, {4'h2, 7'd43}, {4'h3, 7'd23},
    {4'h4, 7'd51},  {4'h5, 7'd27}, {4'h6, 7'd27}, {4'h7, 7'd15},
    {4'h8, 7'd27},  {4'h9, 7'd15}, {4'hA, 7'd9},  {4'hB, 7'd9},
    {4'hC, 7'd27},  {4'hD, 7'd15}, {4'hE, 7'd9},  {4'hF, 7'd9}
  };

  always #(CLK_NS/2) clk = ~clk;

  i2c_start_resv dut_i (
    .clk(clk), .rst(rst), .start_req(start_req), .resv_dis(resv_dis),
    .bus_free(bus_free), .stop_det(stop_det), .slave_hit(slave_hit),
    .master_drop(master_drop), .stop_ie(stop_ie), .speed_code(speed_code),
    .addr_wr(addr_wr), .addr_in(addr_in), .start_gen(start_gen),
    .master_sts(master_sts), .resv_pend(resv_pend), .wait_done(wait_done),
    .stop_irq(stop_irq), .launch_addr(launch_addr), .launch_valid(launch_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: inputs already set at a negedge; return at the next negedge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    start_req = 0; stop_det = 0; slave_hit = 0; master_drop = 0; addr_wr = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    check("R1 start_gen", start_gen, 0);
    check("R1 master_sts", master_sts, 0);
    rst = 0;
    tick();
    check("R1 resv_pend", resv_pend, 0);
    check("R1 wait_done", wait_done, 0);
    check("R1 stop_irq", stop_irq, 0);
    check("R1 launch_valid", launch_valid, 0);

    // R8: wait length table, walked with requests ignored by the FSM (R4 setting)
    bus_free = 0; resv_dis = 1;
    for (int v = 0; v < NVEC; v++) begin
      int n;
      int hit;
      speed_code = VEC[v][10:7];
      n = int'(VEC[v][6:0]);
      hit = -1;
      start_req = 1;
      tick();
      start_req = 0;
      for (int j = 1; j <= n + 2; j++) begin
        tick();
        if (wait_done && hit < 0) hit = j;
      end
      check($sformatf("R8 wait code %0d", v), hit, n);
    end
    check("R4 no pend after table", resv_pend, 0);
    check("R4 no master after table", master_sts, 0);

    // R8: restart by a second request mid-count
    speed_code = 4'hA;   // 9 clocks
    start_req = 1; tick(); start_req = 0;
    repeat (4) tick();
    start_req = 1; tick(); start_req = 0;
    begin
      int hit;
      hit = -1;
      for (int j = 1; j <= 12; j++) begin
        tick();
        if (wait_done && hit < 0) hit = j;
      end
      check("R8 restart", hit, 9);
    end

    // R4: disabled reservation dropped, stop creates nothing
    start_req = 1; tick(); start_req = 0;
    check("R4 pend", resv_pend, 0);
    check("R4 gen", start_gen, 0);
    stop_det = 1; tick(); stop_det = 0;
    check("R4 gen after stop", start_gen, 0);
    check("R4 master after stop", master_sts, 0);

    // R2: immediate start on free bus
    resv_dis = 0; bus_free = 1;
    start_req = 1; tick(); start_req = 0;
    check("R2 gen", start_gen, 1);
    check("R2 master", master_sts, 1);
    tick();
    check("R2 gen single", start_gen, 0);
    // R7: request while master
    start_req = 1; tick(); start_req = 0;
    check("R7 gen in master", start_gen, 0);
    check("R7 master kept", master_sts, 1);
    // R9: capture when not pending
    addr_in = 8'hA4; addr_wr = 1; tick(); addr_wr = 0;
    check("R9 valid", launch_valid, 1);
    check("R9 addr", launch_addr, 8'hA4);
    // R10: drop master
    master_drop = 1; tick(); master_drop = 0;
    check("R10 master", master_sts, 0);
    check("R10 valid", launch_valid, 0);

    // R3/R5/R9: reservation on busy bus with stale address
    bus_free = 0;
    addr_in = 8'h33; addr_wr = 1; tick(); addr_wr = 0;
    check("R9 stale loaded", launch_valid, 1);
    start_req = 1; tick(); start_req = 0;
    check("R3 pend", resv_pend, 1);
    check("R3 no gen", start_gen, 0);
    addr_in = 8'h77; addr_wr = 1; tick(); addr_wr = 0;
    check("R9 discard addr", launch_addr, 8'h33);
    start_req = 1; tick(); start_req = 0;
    check("R7 still pend", resv_pend, 1);
    check("R7 no gen", start_gen, 0);
    stop_det = 1; tick(); stop_det = 0;
    check("R5 gen", start_gen, 1);
    check("R5 master", master_sts, 1);
    check("R5 pend cleared", resv_pend, 0);
    check("R9 stale cleared", launch_valid, 0);
    addr_in = 8'h5A; addr_wr = 1; tick(); addr_wr = 0;
    check("R9 post-stop valid", launch_valid, 1);
    check("R9 post-stop addr", launch_addr, 8'h5A);
    master_drop = 1; tick(); master_drop = 0;

    // R6: cancel by slave hit, later stop gives nothing
    start_req = 1; tick(); start_req = 0;
    check("R6 pend set", resv_pend, 1);
    slave_hit = 1; tick(); slave_hit = 0;
    check("R6 pend cleared", resv_pend, 0);
    stop_det = 1; tick(); stop_det = 0;
    check("R6 no gen on stop", start_gen, 0);
    check("R6 no master", master_sts, 0);
    // R6: slave hit and stop together
    start_req = 1; tick(); start_req = 0;
    slave_hit = 1; stop_det = 1; tick(); pulse_clear();
    check("R6 same-cycle gen", start_gen, 0);
    check("R6 same-cycle pend", resv_pend, 0);

    // R11: stop interrupt
    stop_ie = 1; stop_det = 1; tick(); stop_det = 0;
    check("R11 irq", stop_irq, 1);
    tick();
    check("R11 irq single", stop_irq, 0);
    stop_ie = 0; stop_det = 1; tick(); stop_det = 0;
    check("R11 irq masked", stop_irq, 0);

    finish_run();
  end

endmodule